// File: doc/BRIEF.md
# Free-running slow-clock timestamp counter

This block is a free-running timestamp counter. It counts on a slow clock of about 32 kHz and is read from a much faster bus clock. The counter advances on every falling edge of the slow clock. While the power-on reset is low, the counter stays at zero. Once the reset is released, the counter runs without stopping and rolls over to zero after its all-ones value.

The count crosses into the bus domain as Gray code. Two synchroniser flops capture it there, and it is turned back into binary. Hosts see that binary value through two read ports:

- **Wide port.** Returns every bit of the count in one access.
- **Split port.** Returns the count as two half-width accesses: the lower half first, then the upper half. Reading the lower half takes a snapshot of the whole value, so the later upper-half read belongs to the same sample even if the count has moved on in between.

The split port is a two-state machine:

- `SPL_IDLE`: no snapshot is pending.
- `SPL_HELD`: a lower half has been read and the matching upper half is waiting.

Its transitions are:

- `IDLE-lo->HELD`: capture the snapshot and return the lower half.
- `IDLE-hi->IDLE`: return the live upper half.
- `HELD-hi->IDLE`: return the held upper half.
- `HELD-lo->HELD`: take a fresh snapshot and return its lower half.

Top module: `tstamp_ctr_top`

## Requirements
- R1: The counter increases by exactly one on each falling edge of `slow_clk` and never on a rising edge.
- R2: While `por_n` is low, the count is zero and both read outputs read zero. After release, the first falling edge of `slow_clk` makes the count one.
- R3: After the all-ones value (CNT_W bits), the next increment gives zero and counting continues.
- R4: The binary value in the bus domain only ever steps by one (modulo 2^CNT_W). With `bus_clk` at least four times `slow_clk`, any read returns the current count or the one just before it.
- R5: The synchronised Gray code in the bus domain changes by at most one bit per `bus_clk` cycle.
- R6: When `rdw_req` is high at a `bus_clk` rising edge, `rdw_data` holds the full bus-domain value from the next cycle on.
- R7: When `rdh_req` is high with `rdh_hi`=0, `rdh_data` returns the lower CNT_W/2 bits in the next cycle. The same read stores the upper half as a snapshot and enters `SPL_HELD`.
- R8: When `rdh_req` is high with `rdh_hi`=1 in `SPL_HELD`, `rdh_data` returns the stored upper half. The state goes back to `SPL_IDLE`.
- R9: When `rdh_req` is high with `rdh_hi`=1 in `SPL_IDLE`, `rdh_data` returns the upper half of the live value.
- R10: A lower-half read in `SPL_HELD` replaces the snapshot. The next upper-half read matches the newer lower half.
- R11: Wide-port reads have no effect on a pending split snapshot.
- R12: Without a request, `rdw_data` and `rdh_data` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| slow_clk | input | 1 | Slow counting clock; the count advances on its falling edge |
| por_n | input | 1 | Power-on reset, active low, asynchronous for both domains |
| bus_clk | input | 1 | Fast read clock, at least 4x `slow_clk` |
| rdw_req | input | 1 | Wide read strobe |
| rdw_data | output | CNT_W | Full count returned by the wide port |
| rdh_req | input | 1 | Split read strobe |
| rdh_hi | input | 1 | Split half select: 0 = lower half, 1 = upper half |
| rdh_data | output | CNT_W/2 | Half-width count returned by the split port |

## Verification
The bench targets three cases:

- **Upper half after the lower half rolls over.** The bench reads the lower half just before the lower half rolls over and reads the upper half just after. A port that served the upper half live would return a value one too high there. The bench also replaces a pending snapshot and then reads the upper half; a design that ignored the second lower-half read would return a stale upper half.
- **Rollover.** A narrow copy of the block is run past its all-ones value. A broken rollover would show as a read outside the window of the count or the one before it.
- **Edge and reset behaviour.** Counting on the wrong clock edge would run the count half a period ahead of the bench model. Counting during reset would leave a non-zero value just after release.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;

    // States of the split (half-width) read port
    typedef enum logic [0:0] {
        SPL_IDLE = 1'b0,
        SPL_HELD = 1'b1
    } spl_state_e;

endpackage

// File: rtl/tstamp_slow_ctr.sv
// Free-running counter in the slow domain, advanced on the falling edge.
// A Gray copy is registered on the same edge so that only one bit of the
// crossing bus ever moves per slow period.
module tstamp_slow_ctr #(
    parameter int W = 32
) (
    input  logic         slow_clk,
    input  logic         por_n,
    output logic [W-1:0] cnt_bin,
    output logic [W-1:0] cnt_gray
);

    logic [W-1:0] cnt_nxt;
    logic [W-1:0] gray_nxt;

    always_comb begin
        cnt_nxt  = cnt_bin + W'(1);
        gray_nxt = cnt_nxt ^ (cnt_nxt >> 1);
    end

    always_ff @(negedge slow_clk or negedge por_n) begin
        if (!por_n) begin
            cnt_bin  <= '0;
            cnt_gray <= '0;
        end else begin
            cnt_bin  <= cnt_nxt;
            cnt_gray <= gray_nxt;
        end
    end

endmodule

// File: rtl/tstamp_rst_sync.sv
// Reset for the bus domain: asserts at once, releases on bus_clk.
module tstamp_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], 1'b1};
        end
    end

    assign rst_n = chain[STAGES-1];

endmodule

// File: rtl/tstamp_gray_sync.sv
// Synchroniser chain for the Gray count, then a registered Gray-to-binary step.
module tstamp_gray_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] gray_sync,
    output logic [W-1:0] bin_out
);

    logic [W-1:0] stage_q [STAGES];

    function automatic logic [W-1:0] gray_to_bin(input logic [W-1:0] g);
        logic [W-1:0] b;
        b[W-1] = g[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= gray_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign gray_sync = stage_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bin_out <= '0;
        else        bin_out <= gray_to_bin(stage_q[STAGES-1]);
    end

endmodule

// File: rtl/tstamp_split_port.sv
// Half-width read port. A lower-half read snapshots the upper half; the
// following upper-half read returns that snapshot.
module tstamp_split_port
    import tstamp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   live,
    input  logic           req,
    input  logic           hi,
    output logic [W/2-1:0] data
);

    localparam int H = W / 2;

    spl_state_e   st_q;
    spl_state_e   st_d;
    logic [H-1:0] snap_hi_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SPL_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (req) begin
            unique case (st_q)
                SPL_IDLE: st_d = hi ? SPL_IDLE : SPL_HELD;
                SPL_HELD: st_d = hi ? SPL_IDLE : SPL_HELD;
                default:  st_d = SPL_IDLE;
            endcase
        end
    end

    // outputs and snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data      <= '0;
            snap_hi_q <= '0;
        end else if (req) begin
            unique case (st_q)
                SPL_IDLE: begin
                    if (hi) begin
                        data <= live[W-1:H];
                    end else begin
                        data      <= live[H-1:0];
                        snap_hi_q <= live[W-1:H];
                    end
                end
                SPL_HELD: begin
                    if (hi) begin
                        data <= snap_hi_q;
                    end else begin
                        data      <= live[H-1:0];
                        snap_hi_q <= live[W-1:H];
                    end
                end
                default: data <= '0;
            endcase
        end
    end

endmodule

// File: rtl/tstamp_ctr_top.sv
module tstamp_ctr_top #(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic               slow_clk,
    input  logic               por_n,
    input  logic               bus_clk,
    input  logic               rdw_req,
    output logic [CNT_W-1:0]   rdw_data,
    input  logic               rdh_req,
    input  logic               rdh_hi,
    output logic [CNT_W/2-1:0] rdh_data
);

    logic             bus_rst_n;
    logic [CNT_W-1:0] cnt_bin;
    logic [CNT_W-1:0] cnt_gray;
    logic [CNT_W-1:0] gray_sync;
    logic [CNT_W-1:0] live_bin;

    tstamp_slow_ctr #(.W(CNT_W)) u_ctr (
        .slow_clk (slow_clk),
        .por_n    (por_n),
        .cnt_bin  (cnt_bin),
        .cnt_gray (cnt_gray)
    );

    tstamp_rst_sync #(.STAGES(2)) u_rst (
        .clk    (bus_clk),
        .arst_n (por_n),
        .rst_n  (bus_rst_n)
    );

    tstamp_gray_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk       (bus_clk),
        .rst_n     (bus_rst_n),
        .gray_in   (cnt_gray),
        .gray_sync (gray_sync),
        .bin_out   (live_bin)
    );

    always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n)   rdw_data <= '0;
        else if (rdw_req) rdw_data <= live_bin;
    end

    tstamp_split_port #(.W(CNT_W)) u_split (
        .clk   (bus_clk),
        .rst_n (bus_rst_n),
        .live  (live_bin),
        .req   (rdh_req),
        .hi    (rdh_hi),
        .data  (rdh_data)
    );

endmodule

// File: rtl/tstamp_chk.sv
module tstamp_chk #(
    parameter int W = 32
) (
    input logic           slow_clk,
    input logic           por_n,
    input logic           bus_clk,
    input logic           bus_rst_n,
    input logic [W-1:0]   cnt_bin,
    input logic [W-1:0]   gray_sync,
    input logic [W-1:0]   live_bin,
    input logic           rdw_req,
    input logic [W-1:0]   rdw_data,
    input logic           rdh_req,
    input logic           rdh_hi,
    input logic [W/2-1:0] rdh_data
);

    localparam int H = W / 2;

    // independent model of the split-port snapshot
    logic         held;
    logic [H-1:0] snap_hi;

    always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n) begin
            held    <= 1'b0;
            snap_hi <= '0;
        end else if (rdh_req) begin
            if (!rdh_hi) begin
                held    <= 1'b1;
                snap_hi <= live_bin[W-1:H];
            end else begin
                held <= 1'b0;
            end
        end
    end

    // R1, R3: slow count steps by one, modulo 2^W
    assert_step_wrap_R3: assert property (@(negedge slow_clk) disable iff (!por_n)
        $past(por_n) |-> ((cnt_bin - $past(cnt_bin)) == W'(1)));

    // R5: at most one Gray bit moves per bus cycle
    assert_gray_onebit_R5: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        $past(bus_rst_n) |-> ($countones(gray_sync ^ $past(gray_sync)) <= 1));

    // R4: bus-domain value only steps by one
    assert_live_step_R4: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        ($past(bus_rst_n) && (live_bin != $past(live_bin))) |->
        ((live_bin - $past(live_bin)) == W'(1)));

    // R6: wide read returns the value present at the request edge
    assert_wide_read_R6: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        rdw_req |=> (rdw_data == $past(live_bin)));

    // R7: lower-half read
    assert_lo_half_R7: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (rdh_req && !rdh_hi) |=> (rdh_data == $past(live_bin[H-1:0])));

    // R8: upper-half read with snapshot pending
    assert_hi_held_R8: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (rdh_req && rdh_hi && held) |=> (rdh_data == $past(snap_hi)));

    // R9: upper-half read without snapshot
    assert_hi_live_R9: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (rdh_req && rdh_hi && !held) |=> (rdh_data == $past(live_bin[W-1:H])));

    // R12: outputs hold without a request
    assert_hold_R12: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (!rdw_req && !rdh_req) |=> ($stable(rdw_data) && $stable(rdh_data)));

endmodule

bind tstamp_ctr_top tstamp_chk #(.W(CNT_W)) u_chk (
    .slow_clk  (slow_clk),
    .por_n     (por_n),
    .bus_clk   (bus_clk),
    .bus_rst_n (bus_rst_n),
    .cnt_bin   (cnt_bin),
    .gray_sync (gray_sync),
    .live_bin  (live_bin),
    .rdw_req   (rdw_req),
    .rdw_data  (rdw_data),
    .rdh_req   (rdh_req),
    .rdh_hi    (rdh_hi),
    .rdh_data  (rdh_data)
);

// File: tb/sim_tstamp_ctr_top.sv
`timescale 1ns/1ps
module sim_tstamp_ctr_top;

    logic        slow_clk = 1'b0;
    logic        bus_clk  = 1'b0;
    logic        por_n    = 1'b0;
    logic        rdw_req  = 1'b0;
    logic        rdh_req  = 1'b0;
    logic        rdh_hi   = 1'b0;
    logic [31:0] w0;
    logic [15:0] h0;
    logic [7:0]  w1;
    logic [3:0]  h1;

    int          vectors = 0;
    int          errors  = 0;
    int          cyc     = 0;
    bit          done    = 1'b0;
    int unsigned m       = 0;   // reference: falling edges since release

    always #4  bus_clk  = ~bus_clk;    // 125 MHz
    always #42 slow_clk = ~slow_clk;   // ratio 10.5

    always @(negedge slow_clk) begin
        if (por_n) m = m + 1;
        else       m = 0;
    end

    tstamp_ctr_top u0 (
        .slow_clk (slow_clk), .por_n (por_n), .bus_clk (bus_clk),
        .rdw_req  (rdw_req),  .rdw_data (w0),
        .rdh_req  (rdh_req),  .rdh_hi (rdh_hi), .rdh_data (h0)
    );

    tstamp_ctr_top #(.CNT_W(8)) u1 (
        .slow_clk (slow_clk), .por_n (por_n), .bus_clk (bus_clk),
        .rdw_req  (rdw_req),  .rdw_data (w1),
        .rdh_req  (rdh_req),  .rdh_hi (rdh_hi), .rdh_data (h1)
    );

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", rq, act, exp, $time);
        end
    endtask

    function automatic longint msk(input int w);
        return (longint'(1) << w) - 1;
    endfunction

    // value is the current count or the previous one
    function automatic bit in_win(input longint act, input int unsigned mm, input int w);
        if (mm == 0) return act == 0;
        return (act == (longint'(mm) & msk(w))) || (act == (longint'(mm - 1) & msk(w)));
    endfunction

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    always @(posedge bus_clk) begin
        cyc++;
        if (cyc >= 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
            report();
        end
    end

    task automatic wide(input string rq);
        @(negedge bus_clk) rdw_req = 1'b1;
        @(negedge bus_clk) rdw_req = 1'b0;
        chk(in_win(w0, m, 32), rq, w0, m);
        chk(in_win(w1, m, 8),  rq, w1, m & 8'hff);
    endtask

    task automatic half(input bit hi);
        @(negedge bus_clk) begin rdh_req = 1'b1; rdh_hi = hi; end
        @(negedge bus_clk) rdh_req = 1'b0;
    endtask

    task automatic wait_lo4(input int r);
        while ((m % 16) != r) @(negedge bus_clk);
    endtask

    initial begin
        longint      v;
        int unsigned mlo;
        logic [7:0]  held_w1;
        logic [3:0]  lo1;

        // R2: held in reset while the slow clock runs
        repeat (6) @(posedge slow_clk);
        @(negedge bus_clk) rdw_req = 1'b1;
        @(negedge bus_clk) rdw_req = 1'b0;
        chk(w0 == 0 && w1 == 0, "R2 reset wide", w0, 0);
        chk(h0 == 0 && h1 == 0, "R2 reset split", h0, 0);
        @(posedge slow_clk) por_n = 1'b1;
        repeat (3) @(negedge bus_clk);
        wide("R2 release");
        chk(w0 <= 1, "R2 not counted in reset", w0, 0);

        // R1/R4/R6: continuous wide reads compared every clock
        @(negedge bus_clk) rdw_req = 1'b1;
        for (int i = 0; i < 300; i++) begin
            @(negedge bus_clk);
            chk(in_win(w0, m, 32), "R1 R4 R6 per-clock", w0, m);
            chk(in_win(w1, m, 8),  "R4 narrow per-clock", w1, m & 8'hff);
        end
        rdw_req = 1'b0;

        // R12: hold without request
        v = w0;
        repeat (40) @(negedge bus_clk);
        chk(w0 == v, "R12 wide hold", w0, v);

        // R7/R8: coherent split across the lower-half rollover of u1
        wait_lo4(15);
        half(1'b0);
        mlo = m; lo1 = h1;
        held_w1 = (lo1 == (mlo & 8'hf)) ? 8'(mlo) : 8'(mlo - 1);
        chk(in_win({4'h0, lo1}, mlo & 4'hf, 4) || in_win(held_w1, mlo, 8), "R7 lo half", lo1, mlo & 4'hf);
        chk(in_win(h0, mlo, 16), "R7 lo half wide", h0, mlo);
        wait_lo4(2);
        // R11: wide read between halves leaves the snapshot alone
        wide("R11 wide between halves");
        half(1'b1);
        chk(h1 == held_w1[7:4], "R8 coherent upper", h1, held_w1[7:4]);
        chk(h0 == 0, "R8 upper u0", h0, 0);

        // R9: upper read with nothing pending follows the live count
        wait_lo4(3);
        half(1'b1);
        chk(h1 == 4'(m >> 4) || h1 == 4'((m - 1) >> 4), "R9 live upper", h1, 4'(m >> 4));

        // R10: second lower read replaces the snapshot
        wait_lo4(14);
        half(1'b0);
        wait_lo4(1);
        half(1'b0);
        mlo = m; lo1 = h1;
        held_w1 = (lo1 == (mlo & 8'hf)) ? 8'(mlo) : 8'(mlo - 1);
        wait_lo4(5);
        half(1'b1);
        chk(h1 == held_w1[7:4], "R10 refreshed snapshot", h1, held_w1[7:4]);

        // R3: run the narrow copy through its rollover
        v = w0;
        while (m < 262) begin
            wide("R3 R4 around wrap");
            chk(((w0 - v) & msk(32)) < 64, "R4 monotonic", w0, v);
            v = w0;
            repeat (3) @(negedge bus_clk);
        end
        wide("R3 after wrap");
        chk(w1 < 16 && w1 == 8'(m) || w1 == 8'(m - 1), "R3 narrow wrapped", w1, m & 8'hff);

        // R2: second reset mid-run
        @(posedge slow_clk) por_n = 1'b0;
        repeat (4) @(posedge slow_clk);
        @(negedge bus_clk);
        chk(w0 == 0 && h0 == 0, "R2 mid-run reset outputs", w0, 0);
        @(posedge slow_clk) por_n = 1'b1;
        repeat (3) @(negedge bus_clk);
        wide("R2 restart");
        chk(w0 <= 1, "R2 restart from zero", w0, 0);
        repeat (30) @(negedge bus_clk);
        wide("R1 after restart");

        report();
    end

endmodule